// File: doc/BRIEF.md
# Kernel Launch Control Register Slave

This block sits between a host-facing AXI4-Lite slave port and the start/finish handshake of a compute core. The host programs the core's scalar arguments into 32-bit slots, then writes a launch bit. The block holds a start request towards the core until the core reports that it has taken its inputs. It also records when the core finishes and whether the core is currently idle.

Completion and input-accepted events are latched into a pending-interrupt register. A per-source mask and a master enable select which pending events drive the active-high interrupt line. The host acknowledges an event by writing a one to its pending bit. Completion is also visible in the control word, and reading that word clears it.

The compute datapath and any memory traffic are outside this block. It contains only the register file, the bus handshake and the interrupt logic.

Top module: `kernel_ctrl_slave`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 except control bit 2, which shows `core_idle`. `core_start`, `irq` and all of `kargs` are 0.
- R2: Writing offset 0x00 with byte lane 0 enabled and data bit 0 set raises `core_start`. It stays high until a cycle in which `core_ready` is high and drops on the following clock edge. Writing 0, or writing with byte lane 0 disabled, leaves it unchanged. Control bit 0 reads back `core_start`.
- R3: A `core_done` pulse sets control bit 1. The bit stays set until a read of offset 0x00 returns it, and that read clears it.
- R4: Control bit 2 returns the level of `core_idle` at the time of the read. Control bit 3 is set by a `core_ready` pulse and cleared by a read of offset 0x00.
- R5: Offset 0x04 bit 0 is the master interrupt enable. Offset 0x08 bits [1:0] are source masks, with bit 0 for completion and bit 1 for input-accepted. Both are read/write through byte lane 0, and all other bits read 0.
- R6: Offset 0x0C bit 0 is set by `core_done` and bit 1 by `core_ready`, whatever the masks hold. Writing 1 to a bit through byte lane 0 clears it, and writing 0 leaves it unchanged.
- R7: `irq` equals master enable AND the OR of (mask AND pending) over both sources. It reflects a register update from the next cycle on.
- R8: Argument slot i is at offset 0x10 + 4*i and is read/write. Only byte lanes whose WSTRB bit is set are written. `kargs[32*i +: 32]` always shows slot i.
- R9: Reads of unmapped offsets return 0 and writes to them change nothing. Every write response and read response is OKAY (2'b00).
- R10: At most one write and one read are in flight. Address and data are taken together, only when both are valid and no write response is waiting. `s_bvalid` is held until `s_bready`. `s_arready` is low while `s_rvalid` is high, and read data stays stable until `s_rready`.
- R11: A core event beats a clear in the same cycle. A `core_done` that coincides with a control-word read leaves bit 1 set, and that read returns the old value. A `core_done` that coincides with a write-1 to pending bit 0 leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte lanes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | Launch request to the core |
| core_done | input | 1 | Core finished (one-cycle pulse) |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core took its inputs (one-cycle pulse) |
| kargs | output | NUM_ARGS*32 | Argument slots, slot 0 in the low bits |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest situation to reach is a core event landing in exactly the cycle where the host clears the same flag. This happens when `core_done` coincides with the accepted read of the control word, or with a write-1 to the pending register. The bench drives the core handshake inputs itself rather than through a core model. That lets it raise `core_done` on the same falling edge as it presents the read or write address, so both land on one rising edge. It then reads again to see that the flag survived. The mask, enable and pending combinations are swept completely, 32 cases, with the interrupt level computed from the R7 formula.

// File: rtl/kctl_pkg.sv
// Shared constants for the kernel control slave: data width, register word
// indices and bit positions inside the control and interrupt registers.
package kctl_pkg;
    localparam int DATA_W     = 32;
    localparam int STRB_W     = DATA_W / 8;
    // word index = byte offset / 4
    localparam int IDX_CTRL   = 0;
    localparam int IDX_GIE    = 1;
    localparam int IDX_IER    = 2;
    localparam int IDX_ISR    = 3;
    localparam int IDX_ARG0   = 4;
    // control word bits
    localparam int CTRL_START = 0;
    localparam int CTRL_DONE  = 1;
    localparam int CTRL_IDLE  = 2;
    localparam int CTRL_READY = 3;
    // interrupt source bits
    localparam int SRC_W      = 2;
endpackage

// File: rtl/kctl_axil_port.sv
// AXI4-Lite slave handshake. Accepts one write (address and data together)
// and one read at a time, turns them into single-cycle register strobes,
// and registers the read data. Assumes word-aligned accesses; the two low
// address bits are ignored. Responses are always OKAY.
module kctl_axil_port
    import kctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              w_valid,
    output logic              w_ready,
    output logic [1:0]        b_resp,
    output logic              b_valid,
    input  logic              b_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic              ar_valid,
    output logic              ar_ready,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              r_valid,
    input  logic              r_ready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data
);
    logic              bvalid_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_lsbs;

    assign unused_lsbs = ^{aw_addr[1:0], ar_addr[1:0]};

    // Write is taken only when address and data are both present and no response waits.
    assign wr_en    = aw_valid & w_valid & ~bvalid_q;
    assign aw_ready = wr_en;
    assign w_ready  = wr_en;
    assign wr_idx   = aw_addr[ADDR_W-1:2];
    assign wr_data  = w_data;
    assign wr_strb  = w_strb;

    // Read is taken only when no read data waits.
    assign ar_ready = ~rvalid_q;
    assign rd_en    = ar_valid & ~rvalid_q;
    assign rd_idx   = ar_addr[ADDR_W-1:2];

    assign b_valid = bvalid_q;
    assign b_resp  = 2'b00;
    assign r_valid = rvalid_q;
    assign r_data  = rdata_q;
    assign r_resp  = 2'b00;

    // Write response valid: set by an accepted write, held until taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       bvalid_q <= 1'b0;
        else if (wr_en)   bvalid_q <= 1'b1;
        else if (b_ready) bvalid_q <= 1'b0;
    end

    // Read data valid: set by an accepted read, held until taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       rvalid_q <= 1'b0;
        else if (rd_en)   rvalid_q <= 1'b1;
        else if (r_ready) rvalid_q <= 1'b0;
    end

    // Read data register: captures the register view at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_data;
    end

    // R10
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid_q && !b_ready |=> bvalid_q);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q && !r_ready |=> rvalid_q && $stable(rdata_q));
endmodule

// File: rtl/kctl_regfile.sv
// Control, interrupt and argument registers of the kernel control slave.
// Takes single-cycle write/read strobes from the bus port and the core
// handshake pulses. Assumes core_done and core_ready are single-cycle pulses.
// A core event wins over a clear in the same cycle.
module kctl_regfile
    import kctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_ARGS = 4,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [STRB_W-1:0]          wr_strb,
    input  logic                       rd_en,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       core_start,
    input  logic                       core_done,
    input  logic                       core_idle,
    input  logic                       core_ready,
    output logic [NUM_ARGS*DATA_W-1:0] kargs,
    output logic                       irq
);
    logic              start_q, done_q, rdy_q, gie_q;
    logic [SRC_W-1:0]  ier_q, isr_q, isr_clr, src_evt;
    logic              wr_ctrl, wr_gie, wr_ier, wr_isr, rd_ctrl, start_set;
    logic [NUM_ARGS*DATA_W-1:0] arg_flat;

    assign wr_ctrl   = wr_en && (wr_idx == IDX_W'(IDX_CTRL));
    assign wr_gie    = wr_en && (wr_idx == IDX_W'(IDX_GIE)) && wr_strb[0];
    assign wr_ier    = wr_en && (wr_idx == IDX_W'(IDX_IER)) && wr_strb[0];
    assign wr_isr    = wr_en && (wr_idx == IDX_W'(IDX_ISR)) && wr_strb[0];
    assign rd_ctrl   = rd_en && (rd_idx == IDX_W'(IDX_CTRL));
    assign start_set = wr_ctrl && wr_strb[0] && wr_data[CTRL_START];
    assign isr_clr   = wr_isr ? wr_data[SRC_W-1:0] : '0;
    assign src_evt   = {core_ready, core_done};

    // Launch request: set by host write, dropped after the core reports ready.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_q <= 1'b0;
        else if (start_set)  start_q <= 1'b1;
        else if (core_ready) start_q <= 1'b0;
    end

    // Sticky done and ready flags of the control word, cleared by reading it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            rdy_q  <= 1'b0;
        end else begin
            if (core_done)    done_q <= 1'b1;
            else if (rd_ctrl) done_q <= 1'b0;
            if (core_ready)   rdy_q  <= 1'b1;
            else if (rd_ctrl) rdy_q  <= 1'b0;
        end
    end

    // Master enable and per-source masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            ier_q <= '0;
        end else begin
            if (wr_gie) gie_q <= wr_data[0];
            if (wr_ier) ier_q <= wr_data[SRC_W-1:0];
        end
    end

    // Pending sources: events set, write-1 clears, event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~isr_clr) | src_evt;
    end

    // Argument slots, one register per byte lane.
    for (genvar a = 0; a < NUM_ARGS; a++) begin : g_arg
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(IDX_ARG0 + a));
        for (genvar b = 0; b < STRB_W; b++) begin : g_lane
            logic [7:0] byte_q;
            // Byte lane b of slot a, written only when its strobe is set.
            always_ff @(posedge clk) begin
                if (!rst_n)                byte_q <= '0;
                else if (hit && wr_strb[b]) byte_q <= wr_data[b*8 +: 8];
            end
            assign arg_flat[a*DATA_W + b*8 +: 8] = byte_q;
        end
    end

    // Read view of the register map; unmapped words read zero.
    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_W'(IDX_CTRL)) begin
            rd_data[CTRL_START] = start_q;
            rd_data[CTRL_DONE]  = done_q;
            rd_data[CTRL_IDLE]  = core_idle;
            rd_data[CTRL_READY] = rdy_q;
        end else if (rd_idx == IDX_W'(IDX_GIE)) begin
            rd_data[0] = gie_q;
        end else if (rd_idx == IDX_W'(IDX_IER)) begin
            rd_data[SRC_W-1:0] = ier_q;
        end else if (rd_idx == IDX_W'(IDX_ISR)) begin
            rd_data[SRC_W-1:0] = isr_q;
        end
        for (int i = 0; i < NUM_ARGS; i++) begin
            if (rd_idx == IDX_W'(IDX_ARG0 + i)) rd_data = arg_flat[i*DATA_W +: DATA_W];
        end
    end

    assign core_start = start_q;
    assign kargs      = arg_flat;
    assign irq        = gie_q & |(ier_q & isr_q);

    // R2
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q && !core_ready |=> start_q);

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q && core_ready && !start_set |=> !start_q);

    // R3
    done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_q);

    // R6
    ready_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> isr_q[1]);

    // R5
    gie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gie |=> gie_q == $past(wr_data[0]));
endmodule

// File: rtl/kernel_ctrl_slave.sv
// Top of the kernel control slave: AXI4-Lite port plus the launch,
// interrupt and argument register file. Single clock, synchronous
// active-low reset.
module kernel_ctrl_slave
    import kctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_ARGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          s_awaddr,
    input  logic                       s_awvalid,
    output logic                       s_awready,
    input  logic [31:0]                s_wdata,
    input  logic [3:0]                 s_wstrb,
    input  logic                       s_wvalid,
    output logic                       s_wready,
    output logic [1:0]                 s_bresp,
    output logic                       s_bvalid,
    input  logic                       s_bready,
    input  logic [ADDR_W-1:0]          s_araddr,
    input  logic                       s_arvalid,
    output logic                       s_arready,
    output logic [31:0]                s_rdata,
    output logic [1:0]                 s_rresp,
    output logic                       s_rvalid,
    input  logic                       s_rready,
    output logic                       core_start,
    input  logic                       core_done,
    input  logic                       core_idle,
    input  logic                       core_ready,
    output logic [NUM_ARGS*32-1:0]     kargs,
    output logic                       irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic              wr_en, rd_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [STRB_W-1:0] wr_strb;

    kctl_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .aw_addr(s_awaddr), .aw_valid(s_awvalid), .aw_ready(s_awready),
        .w_data(s_wdata), .w_strb(s_wstrb), .w_valid(s_wvalid), .w_ready(s_wready),
        .b_resp(s_bresp), .b_valid(s_bvalid), .b_ready(s_bready),
        .ar_addr(s_araddr), .ar_valid(s_arvalid), .ar_ready(s_arready),
        .r_data(s_rdata), .r_resp(s_rresp), .r_valid(s_rvalid), .r_ready(s_rready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    kctl_regfile #(.ADDR_W(ADDR_W), .NUM_ARGS(NUM_ARGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .core_ready(core_ready), .kargs(kargs), .irq(irq)
    );
endmodule

// File: tb/kernel_ctrl_slave_test.sv
// Self-checking bench: drives the bus and the core handshake directly.
module kernel_ctrl_slave_test;
    localparam int ADDR_W = 8;
    localparam int NARGS  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic cstart, cdone = 0, cidle = 0, cready = 0, irq;
    logic [NARGS*32-1:0] kargs;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    kernel_ctrl_slave #(.ADDR_W(ADDR_W), .NUM_ARGS(NARGS)) uut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_start(cstart), .core_done(cdone), .core_idle(cidle),
        .core_ready(cready), .kargs(kargs), .irq(irq)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R9 bvalid/bresp", {29'd0, bvalid, bresp}, 32'd4);
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1; rready = 1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        check("R9 rvalid/rresp", {29'd0, rvalid, rresp}, 32'd4);
        d = rdata;
    endtask

    task automatic pulse(logic d, logic r);
        @(negedge clk);
        cdone = d; cready = r;
        @(negedge clk);
        cdone = 0; cready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] expv;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        check("R1 core_start", {31'd0, cstart}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 kargs", {31'd0, |kargs}, 0);
        for (int w = 0; w < 4 + NARGS; w++) begin
            rd(ADDR_W'(4 * w), v);
            check("R1 register", v, 0);
        end

        // R2 launch bit
        wr(8'h00, 32'h0, 4'hF);
        check("R2 write 0 no start", {31'd0, cstart}, 0);
        wr(8'h00, 32'h1, 4'hE);
        check("R2 lane 0 disabled no start", {31'd0, cstart}, 0);
        wr(8'h00, 32'h1, 4'h1);
        check("R2 start raised", {31'd0, cstart}, 1);
        repeat (4) @(negedge clk);
        check("R2 start held", {31'd0, cstart}, 1);
        rd(8'h00, v);
        check("R2 ctrl bit0 readback", v, 32'h1);
        pulse(0, 1);
        check("R2 start dropped after ready", {31'd0, cstart}, 0);
        // R4 ready flag latched then cleared by read
        rd(8'h00, v);
        check("R4 ready flag", v, 32'h8);
        rd(8'h00, v);
        check("R4 ready cleared by read", v, 32'h0);

        // R3 done flag clear-on-read
        pulse(1, 0);
        rd(8'h00, v);
        check("R3 done flag", v, 32'h2);
        rd(8'h00, v);
        check("R3 done cleared by read", v, 32'h0);

        // R4 idle level
        cidle = 1;
        rd(8'h00, v);
        check("R4 idle high", v, 32'h4);
        cidle = 0;
        rd(8'h00, v);
        check("R4 idle low", v, 32'h0);

        // R5 enable registers
        wr(8'h04, 32'hFFFF_FFFF, 4'hF);
        rd(8'h04, v);
        check("R5 gie", v, 32'h1);
        wr(8'h08, 32'hFFFF_FFFF, 4'hF);
        rd(8'h08, v);
        check("R5 ier", v, 32'h3);
        wr(8'h08, 32'h0, 4'hE);
        rd(8'h08, v);
        check("R5 ier lane 0 off", v, 32'h3);

        // R6 / R7 exhaustive sweep of enable, mask and pending
        for (int g = 0; g < 2; g++) begin
            for (int m = 0; m < 4; m++) begin
                for (int p = 0; p < 4; p++) begin
                    wr(8'h04, 32'h0, 4'h1);
                    wr(8'h0C, 32'h3, 4'h1);
                    pulse(p[0], p[1]);
                    wr(8'h08, 32'(m), 4'h1);
                    wr(8'h04, 32'(g), 4'h1);
                    rd(8'h0C, v);
                    check("R6 pending", v, 32'(p));
                    expv = 32'((g != 0) && ((m & p) != 0));
                    check("R7 irq", {31'd0, irq}, expv);
                end
            end
        end
        rd(8'h00, v); // drain sticky control flags
        wr(8'h0C, 32'h3, 4'h1);
        pulse(1, 1);
        wr(8'h0C, 32'h1, 4'h1);
        rd(8'h0C, v);
        check("R6 write-1 clears bit0 only", v, 32'h2);
        wr(8'h0C, 32'h0, 4'h1);
        rd(8'h0C, v);
        check("R6 write 0 keeps", v, 32'h2);
        wr(8'h0C, 32'h2, 4'hE);
        rd(8'h0C, v);
        check("R6 lane 0 off keeps", v, 32'h2);
        wr(8'h0C, 32'h2, 4'h1);
        rd(8'h0C, v);
        check("R6 bit1 cleared", v, 32'h0);

        // R8 argument slots with byte lanes
        for (int i = 0; i < NARGS; i++) wr(ADDR_W'(16 + 4 * i), 32'h1122_3344 + 32'(i), 4'hF);
        for (int i = 0; i < NARGS; i++) begin
            rd(ADDR_W'(16 + 4 * i), v);
            check("R8 arg readback", v, 32'h1122_3344 + 32'(i));
            check("R8 kargs slice", kargs[i*32 +: 32], 32'h1122_3344 + 32'(i));
        end
        for (int s = 0; s < 16; s++) begin
            wr(8'h14, 32'h0, 4'hF);
            wr(8'h14, 32'hA5C3_7E19, 4'(s));
            expv = 32'h0;
            for (int b = 0; b < 4; b++) if (s[b]) expv[b*8 +: 8] = 8'(32'hA5C3_7E19 >> (8 * b));
            rd(8'h14, v);
            check("R8 strobe merge", v, expv);
            check("R8 kargs strobe merge", kargs[63:32], expv);
        end

        // R9 unmapped offset
        wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
        rd(8'h3C, v);
        check("R9 unmapped reads 0", v, 0);
        check("R9 unmapped write no effect", kargs[31:0], 32'h1122_3344);

        // R10 write response held, second write stalled
        @(negedge clk);
        awaddr = 8'h10; wdata = 32'h0000_0055; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
        @(posedge clk);
        @(negedge clk);
        wdata = 32'h0000_0066;
        repeat (3) @(negedge clk);
        check("R10 bvalid held", {31'd0, bvalid}, 1);
        check("R10 awready low while response waits", {31'd0, awready}, 0);
        check("R10 stalled write not applied", kargs[31:0], 32'h55);
        awvalid = 0; wvalid = 0; bready = 1;
        @(negedge clk);
        check("R10 bvalid taken", {31'd0, bvalid}, 0);
        // R10 read data held
        @(negedge clk);
        araddr = 8'h10; arvalid = 1; rready = 0;
        @(posedge clk);
        @(negedge clk);
        araddr = 8'h14;
        repeat (3) @(negedge clk);
        check("R10 rvalid held", {31'd0, rvalid}, 1);
        check("R10 arready low", {31'd0, arready}, 0);
        check("R10 rdata stable", rdata, 32'h55);
        arvalid = 0; rready = 1;
        @(negedge clk);

        // R11 event coincides with clear-on-read
        rd(8'h00, v);
        @(negedge clk);
        araddr = 8'h00; arvalid = 1; rready = 1; cdone = 1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 0; cdone = 0;
        check("R11 coincident read returns old", rdata, 32'h0);
        rd(8'h00, v);
        check("R11 done survives coincident read", v, 32'h2);
        // R11 event coincides with write-1 clear
        wr(8'h0C, 32'h3, 4'h1);
        @(negedge clk);
        awaddr = 8'h0C; wdata = 32'h1; wstrb = 4'h1; awvalid = 1; wvalid = 1; bready = 1; cdone = 1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0; cdone = 0;
        rd(8'h0C, v);
        check("R11 pending survives coincident clear", v, 32'h1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule